// File: doc/BRIEF.md
# ADC Output Formatter with DDR Serializer

This block sits between the digital correction stage of a pipelined converter and the data pads. Each 14-bit two's-complement result comes with a positive and a negative over-range flag. The block builds the output word in three steps. It chooses between two's-complement and offset-binary coding. It forces a full-scale code when the sample is out of range. It can also replace the sample with a programmable test pattern. The word is then sent off-chip in one of two ways. In double-data-rate mode, seven lanes each carry two bits per sample. In parallel mode, fourteen pins carry the whole word. A forwarded clock goes out with the data in both modes.

The block runs on a core clock at twice the sample rate. A small state machine splits each sample period into two halves:

- `ST_LOW`: the forwarded clock is low.
- `ST_HIGH`: the forwarded clock is high.

The other states are `ST_IDLE`, which holds after reset, and `ST_PARK`, which holds while the outputs are disabled. The transitions are:

- `ST_IDLE -> ST_LOW` (capture)
- `ST_LOW -> ST_HIGH` (always)
- `ST_HIGH -> ST_LOW` (capture)
- `ST_HIGH -> ST_PARK` or `ST_IDLE -> ST_PARK` (disable requested)
- `ST_PARK -> ST_PARK` (still disabled)
- `ST_PARK -> ST_LOW` (capture on release)

A new sample, the over-range state and the selected interface are registered on every edge that leaves `ST_IDLE`, `ST_HIGH` or `ST_PARK`. The data outputs reflect the captured word from the start of the following `ST_LOW`.

Format and interface each come from a 2-bit register field. Some field codes hand the choice to an external strap pin.

Top module: `adc_ofmt`

## Requirements
- R1: With two's-complement coding, an in-range sample is output unchanged. With offset-binary coding, it is output with bit 13 inverted.
- R2: The format field `fmt_sel` decodes as follows: 2'b10 gives two's complement, 2'b11 gives offset binary, and any other code follows `pin_fmt_ob` (1 = offset binary).
- R3: When `smp_ovr_pos` is high, the word is 14'h1FFF in two's complement and 14'h3FFF in offset binary. When only `smp_ovr_neg` is high, the word is 14'h2000 in two's complement and 14'h0000 in offset binary. When both flags are high, the positive code wins.
- R4: `ovr_flag` is high for the whole sample period, in both halves, of every captured sample with either over-range flag set. It is low otherwise, regardless of interface, pattern or output disable.
- R5: When `pat_en` is high, `pat_word` is output verbatim, unaffected by coding and over-range.
- R6: In DDR mode, while `clk_fwd` is low (the half after its falling edge), lane k carries word bit 2k. While `clk_fwd` is high, lane k carries bit 2k+1. `par_data` stays 0.
- R7: In parallel mode, `par_data` holds the whole word through both halves, with the `clk_fwd` rising edge in mid-word. `ddr_lane` stays 0.
- R8: The interface field `ifc_sel` decodes as follows: 2'b01 gives DDR, 2'b11 gives parallel, and 2'b00 or 2'b10 follow `pin_ifc_par` (1 = parallel). Code 2'b01 must select DDR even with `pin_ifc_par` high.
- R9: While `out_dis` is high at a capture edge, the block parks. `pad_oe` goes low and `clk_fwd`, `ddr_lane` and `par_data` are held at 0. The next edge with `out_dis` low resumes with a fresh capture.
- R10: During and right after reset, `pad_oe`, `clk_fwd`, `ovr_flag`, `ddr_lane` and `par_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_data | input | 14 | Two's-complement conversion result |
| smp_ovr_pos | input | 1 | Sample above positive full scale |
| smp_ovr_neg | input | 1 | Sample below negative full scale |
| fmt_sel | input | 2 | Coding field (see R2) |
| ifc_sel | input | 2 | Interface field (see R8) |
| pin_fmt_ob | input | 1 | Strap: 1 = offset binary |
| pin_ifc_par | input | 1 | Strap: 1 = parallel interface |
| pat_en | input | 1 | Replace data with test pattern |
| pat_word | input | 14 | Custom test pattern |
| out_dis | input | 1 | Disable data and clock outputs |
| pad_oe | output | 1 | Pad driver enable, low = high impedance |
| clk_fwd | output | 1 | Forwarded output clock |
| ddr_lane | output | 7 | DDR lanes, two bits each per sample |
| par_data | output | 14 | Parallel data word |
| ovr_flag | output | 1 | Over-range indicator |

## Verification
Several kinds of sample feed the block:

- Plain mid-range samples, under both codings. They separate a correct MSB inversion from a pass-through.
- Alternating-bit words such as 14'h2AAA and 14'h1555. They expose any swap of even and odd bits between the two clock halves, or a lane shifted by one.
- Over-range samples, including one with both flags set. They confirm the four full-scale codes and that the positive code wins.
- Samples under an active pattern, with over-range also raised. They show that the pattern bypasses both coding and clamping, while the flag still follows the sample.

Strap pins are set opposite to the forcing field codes, so that a decode which wrongly follows the pin is caught.

// File: rtl/ofmt_pkg.sv
package ofmt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_PARK = 2'd3
    } ser_state_t;

    // Returns 1 when offset binary coding is in force.
    function automatic logic use_offset_bin(input logic [1:0] fld, input logic strap_ob);
        logic r;
        case (fld)
            2'b10:   r = 1'b0;
            2'b11:   r = 1'b1;
            default: r = strap_ob;
        endcase
        return r;
    endfunction

    // Returns 1 when the DDR lane interface is in force.
    function automatic logic use_ddr(input logic [1:0] fld, input logic strap_par);
        logic r;
        case (fld)
            2'b01:   r = 1'b1;
            2'b11:   r = 1'b0;
            default: r = ~strap_par;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ofmt_select.sv
module ofmt_select #(
    parameter int W = 14
) (
    input  logic [W-1:0] smp,
    input  logic         ovr_pos,
    input  logic         ovr_neg,
    input  logic         offset_bin,
    input  logic         pat_en,
    input  logic [W-1:0] pat,
    output logic [W-1:0] word
);
    localparam logic [W-1:0] SIGN_BIT = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] TC_MAX   = ~SIGN_BIT;
    localparam logic [W-1:0] TC_MIN   = SIGN_BIT;

    logic [W-1:0] clamped;

    always_comb begin
        if (ovr_pos)      clamped = TC_MAX;
        else if (ovr_neg) clamped = TC_MIN;
        else              clamped = smp;
    end

    always_comb begin
        if (pat_en)          word = pat;
        else if (offset_bin) word = clamped ^ SIGN_BIT;
        else                 word = clamped;
    end
endmodule

// File: rtl/ofmt_ser.sv
module ofmt_ser
    import ofmt_pkg::*;
#(
    parameter int W = 14,
    localparam int LANES = W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             out_dis,
    input  logic [W-1:0]     word_in,
    input  logic             ovr_in,
    input  logic             ddr_in,
    output logic             pad_oe,
    output logic             clk_fwd,
    output logic [LANES-1:0] ddr_lane,
    output logic [W-1:0]     par_data,
    output logic             ovr_flag
);
    ser_state_t state_q, state_d;
    logic [W-1:0] word_q;
    logic         ovr_q;
    logic         ddr_q;
    logic         take;
    logic [LANES-1:0] even_bits, odd_bits;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = out_dis ? ST_PARK : ST_LOW;
            ST_LOW:  state_d = ST_HIGH;
            ST_HIGH: state_d = out_dis ? ST_PARK : ST_LOW;
            ST_PARK: state_d = out_dis ? ST_PARK : ST_LOW;
        endcase
    end

    assign take = (state_q != ST_LOW);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Sample capture at the start of every sample period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            ovr_q  <= 1'b0;
            ddr_q  <= 1'b1;
        end else if (take) begin
            word_q <= word_in;
            ovr_q  <= ovr_in;
            ddr_q  <= ddr_in;
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign even_bits[k] = word_q[2*k];
        assign odd_bits[k]  = word_q[2*k+1];
    end

    // Output decode
    always_comb begin
        pad_oe   = 1'b0;
        clk_fwd  = 1'b0;
        ddr_lane = '0;
        par_data = '0;
        ovr_flag = ovr_q;
        unique case (state_q)
            ST_IDLE: ovr_flag = 1'b0;
            ST_LOW: begin
                pad_oe = 1'b1;
                if (ddr_q) ddr_lane = even_bits;
                else       par_data = word_q;
            end
            ST_HIGH: begin
                pad_oe  = 1'b1;
                clk_fwd = 1'b1;
                if (ddr_q) ddr_lane = odd_bits;
                else       par_data = word_q;
            end
            ST_PARK: ;
        endcase
    end
endmodule

// File: rtl/adc_ofmt.sv
module adc_ofmt
    import ofmt_pkg::*;
#(
    parameter int W = 14,
    localparam int LANES = W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     smp_data,
    input  logic             smp_ovr_pos,
    input  logic             smp_ovr_neg,
    input  logic [1:0]       fmt_sel,
    input  logic [1:0]       ifc_sel,
    input  logic             pin_fmt_ob,
    input  logic             pin_ifc_par,
    input  logic             pat_en,
    input  logic [W-1:0]     pat_word,
    input  logic             out_dis,
    output logic             pad_oe,
    output logic             clk_fwd,
    output logic [LANES-1:0] ddr_lane,
    output logic [W-1:0]     par_data,
    output logic             ovr_flag
);
    logic         offset_bin;
    logic         ddr_mode;
    logic [W-1:0] fmt_word;

    assign offset_bin = use_offset_bin(fmt_sel, pin_fmt_ob);
    assign ddr_mode   = use_ddr(ifc_sel, pin_ifc_par);

    ofmt_select #(.W(W)) u_select (
        .smp        (smp_data),
        .ovr_pos    (smp_ovr_pos),
        .ovr_neg    (smp_ovr_neg),
        .offset_bin (offset_bin),
        .pat_en     (pat_en),
        .pat        (pat_word),
        .word       (fmt_word)
    );

    ofmt_ser #(.W(W)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .out_dis  (out_dis),
        .word_in  (fmt_word),
        .ovr_in   (smp_ovr_pos | smp_ovr_neg),
        .ddr_in   (ddr_mode),
        .pad_oe   (pad_oe),
        .clk_fwd  (clk_fwd),
        .ddr_lane (ddr_lane),
        .par_data (par_data),
        .ovr_flag (ovr_flag)
    );
endmodule

// File: rtl/ofmt_chk.sv
module ofmt_chk #(
    parameter int W = 14,
    localparam int LANES = W / 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pad_oe,
    input logic             clk_fwd,
    input logic [LANES-1:0] ddr_lane,
    input logic [W-1:0]     par_data,
    input logic             ovr_flag
);
    a_r9_parked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_oe |-> (!clk_fwd && ddr_lane == '0 && par_data == '0));

    a_r6_clock_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe && !clk_fwd) |=> (pad_oe && clk_fwd));

    a_r7_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe && !clk_fwd) |=> $stable(par_data));

    a_r4_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe && !clk_fwd) |=> $stable(ovr_flag));

    a_r7_one_interface: assert property (@(posedge clk) disable iff (!rst_n)
        (par_data != '0) |-> (ddr_lane == '0));
endmodule

bind adc_ofmt ofmt_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_oe   (pad_oe),
    .clk_fwd  (clk_fwd),
    .ddr_lane (ddr_lane),
    .par_data (par_data),
    .ovr_flag (ovr_flag)
);

// File: tb/adc_ofmt_tb.sv
module adc_ofmt_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] smp_data = '0;
    logic        smp_ovr_pos = 1'b0, smp_ovr_neg = 1'b0;
    logic [1:0]  fmt_sel = 2'b10, ifc_sel = 2'b01;
    logic        pin_fmt_ob = 1'b0, pin_ifc_par = 1'b0;
    logic        pat_en = 1'b0;
    logic [13:0] pat_word = '0;
    logic        out_dis = 1'b0;
    logic        pad_oe, clk_fwd, ovr_flag;
    logic [6:0]  ddr_lane;
    logic [13:0] par_data;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [13:0] word;
        logic        ovr;
        logic        ddr;
        logic        park;
        string       req;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_ofmt dut_i (
        .clk(clk), .rst_n(rst_n), .smp_data(smp_data),
        .smp_ovr_pos(smp_ovr_pos), .smp_ovr_neg(smp_ovr_neg),
        .fmt_sel(fmt_sel), .ifc_sel(ifc_sel),
        .pin_fmt_ob(pin_fmt_ob), .pin_ifc_par(pin_ifc_par),
        .pat_en(pat_en), .pat_word(pat_word), .out_dis(out_dis),
        .pad_oe(pad_oe), .clk_fwd(clk_fwd), .ddr_lane(ddr_lane),
        .par_data(par_data), .ovr_flag(ovr_flag)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: inputs are already set; compute expected word from requirements and queue it.
    task automatic push(input bit exp_ob, input bit exp_ddr, input string req);
        exp_t e;
        if (pat_en)           e.word = pat_word;
        else if (smp_ovr_pos) e.word = exp_ob ? 14'h3FFF : 14'h1FFF;
        else if (smp_ovr_neg) e.word = exp_ob ? 14'h0000 : 14'h2000;
        else                  e.word = exp_ob ? {~smp_data[13], smp_data[12:0]} : smp_data;
        e.ovr  = smp_ovr_pos | smp_ovr_neg;
        e.ddr  = exp_ddr;
        e.park = out_dis;
        e.req  = req;
        sb_q.push_back(e);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_half(input exp_t e, input bit hi);
        logic [6:0] lanes_exp;
        for (int k = 0; k < 7; k++) lanes_exp[k] = hi ? e.word[2*k+1] : e.word[2*k];
        if (e.park) begin
            chk(!pad_oe && !clk_fwd, {e.req, " R9 pads"}, {30'd0, pad_oe, clk_fwd}, 32'd0);
            chk(ddr_lane == 7'd0 && par_data == 14'd0, {e.req, " R9 data"},
                {11'd0, ddr_lane, par_data}, 32'd0);
        end else begin
            chk(pad_oe && clk_fwd == hi, {e.req, " R6 clock"}, {30'd0, pad_oe, clk_fwd}, {30'd0, 1'b1, hi});
            if (e.ddr) begin
                chk(ddr_lane == lanes_exp, {e.req, " R6 lanes"}, {25'd0, ddr_lane}, {25'd0, lanes_exp});
                chk(par_data == 14'd0, {e.req, " R6 par idle"}, {18'd0, par_data}, 32'd0);
            end else begin
                chk(par_data == e.word, {e.req, " R7 word"}, {18'd0, par_data}, {18'd0, e.word});
                chk(ddr_lane == 7'd0, {e.req, " R7 lanes idle"}, {25'd0, ddr_lane}, 32'd0);
            end
        end
        chk(ovr_flag == e.ovr, {e.req, " R4 flag"}, {31'd0, ovr_flag}, {31'd0, e.ovr});
    endtask

    // Monitor: capture edge, then low half, then high half.
    initial begin
        forever begin
            wait (sb_q.size() > 0);
            @(posedge clk);
            @(negedge clk);
            check_half(sb_q[0], 1'b0);
            @(negedge clk);
            check_half(sb_q[0], 1'b1);
            void'(sb_q.pop_front());
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!pad_oe && !clk_fwd && !ovr_flag && ddr_lane == 0 && par_data == 0, "R10 in reset",
            {29'd0, pad_oe, clk_fwd, ovr_flag}, 32'd0);
        rst_n = 1'b1;
        chk(!pad_oe && !clk_fwd && !ovr_flag && ddr_lane == 0 && par_data == 0, "R10 after reset",
            {29'd0, pad_oe, clk_fwd, ovr_flag}, 32'd0);

        // R1 two's complement, DDR (R8 code 01 against strap high)
        pin_ifc_par = 1'b1; pin_fmt_ob = 1'b1;
        fmt_sel = 2'b10; ifc_sel = 2'b01; smp_data = 14'h1234;
        push(1'b0, 1'b1, "R1 tc R8 ddr");
        // R1 offset binary
        pin_fmt_ob = 1'b0; fmt_sel = 2'b11; smp_data = 14'h0ABC;
        push(1'b1, 1'b1, "R1 ob");
        // R6 alternating patterns
        fmt_sel = 2'b10; smp_data = 14'h2AAA;
        push(1'b0, 1'b1, "R6 alt a");
        smp_data = 14'h1555;
        push(1'b0, 1'b1, "R6 alt b");
        // R3 overloads
        smp_data = 14'h0123; smp_ovr_pos = 1'b1;
        push(1'b0, 1'b1, "R3 pos tc");
        fmt_sel = 2'b11;
        push(1'b1, 1'b1, "R3 pos ob");
        smp_ovr_pos = 1'b0; smp_ovr_neg = 1'b1;
        push(1'b1, 1'b1, "R3 neg ob");
        fmt_sel = 2'b10;
        push(1'b0, 1'b1, "R3 neg tc");
        smp_ovr_pos = 1'b1;
        push(1'b0, 1'b1, "R3 both pos wins");
        smp_ovr_pos = 1'b0; smp_ovr_neg = 1'b0;
        // R2 strap deferral
        fmt_sel = 2'b00; pin_fmt_ob = 1'b1; smp_data = 14'h0F0F;
        push(1'b1, 1'b1, "R2 strap ob");
        pin_fmt_ob = 1'b0;
        push(1'b0, 1'b1, "R2 strap tc");
        // R7 parallel via field
        fmt_sel = 2'b10; ifc_sel = 2'b11; pin_ifc_par = 1'b0; smp_data = 14'h2F0F;
        push(1'b0, 1'b0, "R7 par field");
        smp_data = 14'h3C3C; fmt_sel = 2'b11;
        push(1'b1, 1'b0, "R7 par ob");
        // R8 strap deferral
        ifc_sel = 2'b00; pin_ifc_par = 1'b1; fmt_sel = 2'b10; smp_data = 14'h0777;
        push(1'b0, 1'b0, "R8 strap par");
        ifc_sel = 2'b10; pin_ifc_par = 1'b0;
        push(1'b0, 1'b1, "R8 strap ddr");
        // R5 pattern bypasses coding and clamp
        pat_en = 1'b1; pat_word = 14'h15A5; fmt_sel = 2'b11; smp_ovr_pos = 1'b1;
        push(1'b1, 1'b1, "R5 pattern ddr");
        ifc_sel = 2'b11; smp_ovr_pos = 1'b0;
        push(1'b1, 1'b0, "R5 pattern par");
        pat_en = 1'b0; ifc_sel = 2'b01; fmt_sel = 2'b10;
        // R9 park, flag still tracks
        out_dis = 1'b1; smp_ovr_neg = 1'b1; smp_data = 14'h0001;
        push(1'b0, 1'b1, "R9 parked");
        smp_ovr_neg = 1'b0;
        push(1'b0, 1'b1, "R9 parked clear");
        out_dis = 1'b0; smp_data = 14'h3001;
        push(1'b0, 1'b1, "R9 resume");

        wait (sb_q.size() == 0);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule